// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This engine moves data out of a configuration item port into system memory on behalf of software. Software places a 16-byte command block (the descriptor) in memory and writes the block's physical address into a 64-bit address register. The write that completes the address starts the engine. The engine reads the descriptor over a memory master port. It can then switch the item port to a new item, copy bytes from the current item into memory, or advance the item's read position without copying. To finish, it writes a completion status over the descriptor's first word.

The address register uses big-endian half ordering. The half at register offset 0 holds address bits 63:32, and the half at offset 4 holds bits 31:0. Writing offset 4 starts the operation, using whatever upper half is currently held. The upper half returns to zero after every operation, so a descriptor below 4 GiB needs only one register write. Register reads do not return the address. They always return a fixed 64-bit identification value that software uses to detect the engine.

On the memory side there is one request channel (valid/ready) and one response channel with no back-pressure. On the item side there is an incoming byte stream (valid/ready) plus two single-cycle command strobes: select an item, and advance the item's position.

Top module: `cfg_dma_engine`

## Requirements
- R1: A register read at offset 0 returns 0x51454D55 and at offset 4 returns 0x20434647, in any state.
- R2: A write to offset 4 while idle starts an operation with descriptor address {upper half, written data}. The upper half is set by a write to offset 0. It is zero after reset and again after each operation.
- R3: The operation begins with four word reads at descriptor address +0, +4, +8 and +12, issued in that order. Memory words are big-endian: the byte at the lowest address is in bits 31:24. The words are, in order: control, length, destination bits 63:32, destination bits 31:0. In the control word, bit 1 is read, bit 2 is skip, bit 3 is select, and bits 31:16 are the item key.
- R4: If select is set, one single-cycle `item_sel_valid` strobe carries the key. It comes before any byte is pulled and before any skip.
- R5: If read is set, `length` bytes are taken from the item stream. Byte i is written with a byte write to destination+i, data in bits 7:0 and bits 31:8 zero, in increasing address order. A length of zero writes nothing.
- R6: If skip is set and read is clear, one single-cycle `item_skip_valid` strobe carries the length. If both are set, only the read is done.
- R7: Every operation ends with a word write to the descriptor address. The data is 0 on success and 1 (bit 0 set) on failure. Bit 0 of the fetched control word has no effect.
- R8: An error response to a descriptor read ends the fetch at once. No select, copy or skip follows, and the status is 1. An error response to a byte write stops the copy, and the status is 1.
- R9: `busy` rises on the edge that accepts a starting write. It falls on the edge that takes the status write's response. While busy, writes to either offset are ignored. While not busy, the engine makes no memory request and no item action.
- R10: A memory request stays asserted with unchanged fields until `mem_req_ready`. Only one request is in flight at a time.
- R11: `item_data_ready` is high only while no memory request is pending or awaiting response. Each accepted byte produces exactly one byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 or 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (identification value) |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_byte | output | 1 | 1 = byte access, 0 = 32-bit word |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 32 | Write data (byte in 7:0) |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 32 | Read data, big-endian |
| item_sel_valid | output | 1 | Select-item strobe |
| item_sel_key | output | 16 | Key of the item to select |
| item_skip_valid | output | 1 | Advance-position strobe |
| item_skip_len | output | 32 | Byte count to advance |
| item_data_valid | input | 1 | Item byte available |
| item_data_ready | output | 1 | Engine takes an item byte |
| item_data | input | 8 | Item byte |

## Verification
Two events can fall in the same cycle: the response to the status write, which completes the operation and clears the upper address half, and a new register write that tries to start an operation or set the upper half. The bench watches for the status write being accepted and drives the register write so that it lands on exactly the edge that consumes the response. Since the engine is still busy on that edge, the write must leave no trace. A start must produce no memory request afterwards. An upper-half write is judged by the next operation started with a single low-half write, whose descriptor reads must target addresses below 4 GiB.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned KEY_W      = 16;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  // identification value returned on register reads
  localparam logic [ADDR_W-1:0] CDMA_ID = 64'h5145_4D55_2043_4647;

  // control word bit positions
  localparam int unsigned CTL_ERR  = 0;
  localparam int unsigned CTL_RD   = 1;
  localparam int unsigned CTL_SKIP = 2;
  localparam int unsigned CTL_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SELECT,
    ST_PULL,
    ST_PUT,
    ST_SKIP,
    ST_WB
  } cdma_state_e;

  typedef struct packed {
    logic              write;
    logic              byte_op;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } cdma_mem_cmd_t;
endpackage

// File: rtl/cdma_addr_reg.sv
module cdma_addr_reg
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              op_done,
  output logic              trig,
  output logic [ADDR_W-1:0] trig_addr
);
  localparam int unsigned HALF_W = ADDR_W - WORD_W;

  logic [HALF_W-1:0] upper_q;
  logic              wr_upper;

  assign wr_upper  = reg_wr && (reg_addr == 3'd0) && !busy;
  assign trig      = reg_wr && (reg_addr == 3'd4) && !busy;
  assign trig_addr = {upper_q, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n)        upper_q <= '0;
    else if (op_done)  upper_q <= '0;
    else if (wr_upper) upper_q <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = CDMA_ID[ADDR_W-1:WORD_W];
      3'd4:    reg_rdata = CDMA_ID[WORD_W-1:0];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdma_mem_port.sv
module cdma_mem_port
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cdma_mem_cmd_t     cmd,
  output logic              cmd_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_byte,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [WORD_W-1:0] mem_rsp_rdata
);
  cdma_mem_cmd_t cmd_q;
  logic          req_q;
  logic          wait_q;

  assign cmd_ready = !req_q && !wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      req_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        cmd_q <= cmd;
        req_q <= 1'b1;
      end
      if (req_q && mem_req_ready) begin
        req_q  <= 1'b0;
        wait_q <= 1'b1;
      end
      if (wait_q && mem_rsp_valid) wait_q <= 1'b0;
    end
  end

  assign rsp_done      = wait_q && mem_rsp_valid;
  assign rsp_err       = mem_rsp_err;
  assign rsp_data      = mem_rsp_rdata;
  assign mem_req_valid = req_q;
  assign mem_req_write = cmd_q.write;
  assign mem_req_byte  = cmd_q.byte_op;
  assign mem_req_addr  = cmd_q.addr;
  assign mem_req_wdata = cmd_q.wdata;
endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [ADDR_W-1:0] trig_addr,
  output logic              busy,
  output logic              op_done,
  output logic              cmd_valid,
  output cdma_mem_cmd_t     cmd,
  input  logic              cmd_ready,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              item_sel_valid,
  output logic [KEY_W-1:0]  item_sel_key,
  output logic              item_skip_valid,
  output logic [WORD_W-1:0] item_skip_len,
  input  logic              item_data_valid,
  output logic              item_data_ready,
  input  logic [7:0]        item_data
);
  cdma_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] desc_q;
  logic [ADDR_W-1:0] dst_q;
  logic [WORD_W-1:0] len_q;
  logic [KEY_W-1:0]  key_q;
  logic              sel_q, rd_q, skip_q;
  logic              err_q;
  logic              issued_q;
  logic [7:0]        byte_q;
  logic [WORD_W-1:0] status;

  always_comb begin
    status          = '0;
    status[CTL_ERR] = err_q;
  end

  assign cmd_valid = !issued_q &&
                     (state_q == ST_FETCH || state_q == ST_PUT || state_q == ST_WB);

  always_comb begin
    cmd = '0;
    case (state_q)
      ST_FETCH: begin
        cmd.addr = desc_q + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
      end
      ST_PUT: begin
        cmd.write   = 1'b1;
        cmd.byte_op = 1'b1;
        cmd.addr    = dst_q;
        cmd.wdata   = {{(WORD_W-8){1'b0}}, byte_q};
      end
      ST_WB: begin
        cmd.write = 1'b1;
        cmd.addr  = desc_q;
        cmd.wdata = status;
      end
      default: cmd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      desc_q   <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      key_q    <= '0;
      sel_q    <= 1'b0;
      rd_q     <= 1'b0;
      skip_q   <= 1'b0;
      err_q    <= 1'b0;
      issued_q <= 1'b0;
      byte_q   <= '0;
    end else begin
      if (cmd_valid && cmd_ready) issued_q <= 1'b1;
      if (rsp_done)               issued_q <= 1'b0;

      case (state_q)
        ST_IDLE: begin
          if (trig) begin
            desc_q  <= trig_addr;
            idx_q   <= '0;
            err_q   <= 1'b0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rsp_done) begin
            if (rsp_err) begin
              err_q   <= 1'b1;
              state_q <= ST_WB;
            end else begin
              case (idx_q)
                2'd0: begin
                  key_q  <= rsp_data[WORD_W-1:WORD_W-KEY_W];
                  sel_q  <= rsp_data[CTL_SEL];
                  rd_q   <= rsp_data[CTL_RD];
                  skip_q <= rsp_data[CTL_SKIP];
                end
                2'd1:    len_q <= rsp_data;
                2'd2:    dst_q[ADDR_W-1:WORD_W] <= rsp_data;
                default: dst_q[WORD_W-1:0] <= rsp_data;
              endcase
              if (idx_q == IDX_W'(DESC_WORDS-1)) state_q <= ST_SELECT;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_SELECT: begin
          if (rd_q)        state_q <= (len_q == '0) ? ST_WB : ST_PULL;
          else if (skip_q) state_q <= ST_SKIP;
          else             state_q <= ST_WB;
        end
        ST_PULL: begin
          if (item_data_valid) begin
            byte_q  <= item_data;
            state_q <= ST_PUT;
          end
        end
        ST_PUT: begin
          if (rsp_done) begin
            if (rsp_err) begin
              err_q   <= 1'b1;
              state_q <= ST_WB;
            end else begin
              dst_q   <= dst_q + 1'b1;
              len_q   <= len_q - 1'b1;
              state_q <= (len_q == WORD_W'(1)) ? ST_WB : ST_PULL;
            end
          end
        end
        ST_SKIP: state_q <= ST_WB;
        ST_WB: begin
          if (rsp_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state_q != ST_IDLE);
  assign op_done         = (state_q == ST_WB) && rsp_done;
  assign item_sel_valid  = (state_q == ST_SELECT) && sel_q;
  assign item_sel_key    = key_q;
  assign item_skip_valid = (state_q == ST_SKIP);
  assign item_skip_len   = len_q;
  assign item_data_ready = (state_q == ST_PULL);
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic               mem_req_byte,
  output logic [63:0]        mem_req_addr,
  output logic [31:0]        mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [31:0]        mem_rsp_rdata,
  output logic               item_sel_valid,
  output logic [15:0]        item_sel_key,
  output logic               item_skip_valid,
  output logic [31:0]        item_skip_len,
  input  logic               item_data_valid,
  output logic               item_data_ready,
  input  logic [7:0]         item_data
);
  logic              trig;
  logic [ADDR_W-1:0] trig_addr;
  logic              op_done;
  logic              cmd_valid;
  cdma_mem_cmd_t     cmd;
  logic              cmd_ready;
  logic              rsp_done;
  logic              rsp_err;
  logic [WORD_W-1:0] rsp_data;

  cdma_addr_reg u_areg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .op_done   (op_done),
    .trig      (trig),
    .trig_addr (trig_addr)
  );

  cdma_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .trig            (trig),
    .trig_addr       (trig_addr),
    .busy            (busy),
    .op_done         (op_done),
    .cmd_valid       (cmd_valid),
    .cmd             (cmd),
    .cmd_ready       (cmd_ready),
    .rsp_done        (rsp_done),
    .rsp_err         (rsp_err),
    .rsp_data        (rsp_data),
    .item_sel_valid  (item_sel_valid),
    .item_sel_key    (item_sel_key),
    .item_skip_valid (item_skip_valid),
    .item_skip_len   (item_skip_len),
    .item_data_valid (item_data_valid),
    .item_data_ready (item_data_ready),
    .item_data       (item_data)
  );

  cdma_mem_port u_mport (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd           (cmd),
    .cmd_ready     (cmd_ready),
    .rsp_done      (rsp_done),
    .rsp_err       (rsp_err),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_byte  (mem_req_byte),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .mem_rsp_rdata (mem_rsp_rdata)
  );
endmodule

// File: rtl/cdma_checker.sv
module cdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic        mem_req_byte,
  input logic [63:0] mem_req_addr,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid,
  input logic        item_sel_valid,
  input logic        item_skip_valid,
  input logic        item_data_ready
);
  // R10: a stalled request keeps every field
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_byte) && $stable(mem_req_wdata));

  // R9: an idle engine is silent on both master sides
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !item_data_ready && !item_sel_valid && !item_skip_valid);

  // R9: busy only starts from a write at offset 4
  a_r9_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd4));

  // R7: busy ends only on a memory response (the status write)
  a_r7_end_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_rsp_valid));

  // R11: at most one item-side action per cycle
  a_r11_single_item_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({item_sel_valid, item_skip_valid, item_data_ready}));

  // R11: a byte is requested only with no memory request outstanding
  a_r11_pull_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    item_data_ready |-> !mem_req_valid);

  // R4: the select strobe sits between fetch and data movement
  a_r4_select_alone: assert property (@(posedge clk) disable iff (!rst_n)
    item_sel_valid |-> !mem_req_valid && busy);
endmodule

bind cfg_dma_engine cdma_checker u_cdma_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (busy),
  .reg_wr          (reg_wr),
  .reg_addr        (reg_addr),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_write   (mem_req_write),
  .mem_req_byte    (mem_req_byte),
  .mem_req_addr    (mem_req_addr),
  .mem_req_wdata   (mem_req_wdata),
  .mem_rsp_valid   (mem_rsp_valid),
  .item_sel_valid  (item_sel_valid),
  .item_skip_valid (item_skip_valid),
  .item_data_ready (item_data_ready)
);

// File: tb/cfg_dma_engine_test.sv
module cfg_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic        mem_req_byte;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        item_sel_valid;
  logic [15:0] item_sel_key;
  logic        item_skip_valid;
  logic [31:0] item_skip_len;
  logic        item_data_valid = 1'b0;
  logic        item_data_ready;
  logic [7:0]  item_data = '0;

  always #10 clk = ~clk;

  cfg_dma_engine uut (.*);

  typedef struct {
    int          kind;   // 0 word read, 1 byte write, 2 word write, 3 select, 4 skip
    logic [63:0] addr;
    logic [31:0] data;
    string       req;
  } ev_t;

  ev_t         expq[$];
  logic [7:0]  mem_m [longint unsigned];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic        exp_busy = 1'b0;
  logic [63:0] err_addr = '1;
  logic [15:0] ref_key = '0, src_key = '0;
  int unsigned ref_off = 0, src_off = 0;
  logic        rsp_pend = 1'b0, rsp_err_p = 1'b0, rsp_is_wb = 1'b0, wb_next = 1'b0;
  logic [31:0] rsp_data_p = '0;
  logic        stalled = 1'b0;
  logic [63:0] st_addr;
  logic [31:0] st_wdata;
  logic        st_write;
  logic        pull_wait = 1'b0;

  function automatic logic [7:0] item_byte(logic [15:0] k, int unsigned off);
    return k[7:0] + (k[15:8] * 8'd3) + (off[7:0] * 8'd13) + 8'h5A;
  endfunction

  function automatic logic [7:0] rd_byte(logic [63:0] a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction

  function automatic logic [31:0] rd_word(logic [63:0] a);
    return {rd_byte(a), rd_byte(a + 1), rd_byte(a + 2), rd_byte(a + 3)};
  endfunction

  task automatic put_word(logic [63:0] a, logic [31:0] w);
    mem_m[a]     = w[31:24];
    mem_m[a + 1] = w[23:16];
    mem_m[a + 2] = w[15:8];
    mem_m[a + 3] = w[7:0];
  endtask

  task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, expv, cyc);
    end
  endtask

  task automatic push_ev(int kind, logic [63:0] a, logic [31:0] d, string req);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    expq.push_back(e);
  endtask

  // Reference model: expected event sequence of one operation
  task automatic plan_op(logic [63:0] desc, logic [31:0] ctl, logic [31:0] len,
                         logic [63:0] dst, output logic [31:0] stat);
    bit abort = 0;
    stat = 32'd0;
    for (int k = 0; k < 4; k++) begin
      push_ev(0, desc + 64'(4 * k), '0, "R3");
      if (desc + 64'(4 * k) == err_addr) begin abort = 1; stat = 32'd1; break; end
    end
    if (!abort) begin
      if (ctl[3]) begin
        push_ev(3, '0, {16'h0, ctl[31:16]}, "R4");
        ref_key = ctl[31:16];
        ref_off = 0;
      end
      if (ctl[1]) begin
        for (int unsigned i = 0; i < len; i++) begin
          push_ev(1, dst + 64'(i), {24'h0, item_byte(ref_key, ref_off)}, "R5");
          ref_off++;
          if (dst + 64'(i) == err_addr) begin stat = 32'd1; break; end
        end
      end else if (ctl[2]) begin
        push_ev(4, '0, len, "R6");
        ref_off += len;
      end
    end
    push_ev(2, desc, stat, stat != 0 ? "R8" : "R7");
  endtask

  task automatic put_desc(logic [63:0] desc, logic [31:0] ctl, logic [31:0] len,
                          logic [63:0] dst);
    put_word(desc, ctl);
    put_word(desc + 4, len);
    put_word(desc + 8, dst[63:32]);
    put_word(desc + 12, dst[31:0]);
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic launch(logic [63:0] desc);
    if (desc[63:32] != 0) reg_write(3'd0, desc[63:32]);
    reg_write(3'd4, desc[31:0]);
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while ((exp_busy || busy || expq.size() != 0) && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(t < 4000, {req, " operation completes"}, 64'(t), 64'd4000);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_op(logic [63:0] desc, logic [31:0] ctl, logic [31:0] len,
                        logic [63:0] dst, string req);
    logic [31:0] st;
    put_desc(desc, ctl, len, dst);
    plan_op(desc, ctl, len, dst, st);
    launch(desc);
    wait_idle(req);
    check(rd_word(desc) == st, st != 0 ? "R8 status in memory" : "R7 status in memory",
          64'(rd_word(desc)), 64'(st));
  endtask

  task automatic collide(logic [2:0] a, logic [31:0] d);
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk); #1;
      if (wb_next) break;
    end
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // Cycle monitor: memory and item models, compared on every clock
  always begin
    @(negedge clk); #8;
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (rst_n) begin
      logic nb;
      check(busy == exp_busy, "R9 busy", 64'(busy), 64'(exp_busy));
      nb = exp_busy;
      // response channel
      mem_rsp_valid = rsp_pend;
      mem_rsp_err   = rsp_err_p;
      mem_rsp_rdata = rsp_data_p;
      if (rsp_pend) pull_wait = 1'b0;
      if (rsp_pend && rsp_is_wb) nb = 1'b0;
      rsp_pend = 1'b0;
      wb_next  = 1'b0;
      // R10: stalled request unchanged
      if (stalled) begin
        check(mem_req_valid && mem_req_addr == st_addr && mem_req_wdata == st_wdata
              && mem_req_write == st_write, "R10 held request",
              mem_req_addr, st_addr);
      end
      // R11: item pull only when memory side quiet
      if (item_data_ready)
        check(!mem_req_valid && !pull_wait && !rsp_pend, "R11 pull while quiet",
              64'(mem_req_valid), 64'd0);
      // request channel
      mem_req_ready = ($urandom_range(0, 3) != 0);
      stalled = mem_req_valid && !mem_req_ready;
      st_addr = mem_req_addr; st_wdata = mem_req_wdata; st_write = mem_req_write;
      if (mem_req_valid && mem_req_ready) begin
        int kind;
        kind = !mem_req_write ? 0 : (mem_req_byte ? 1 : 2);
        pull_wait = 1'b1;
        if (expq.size() == 0) begin
          check(0, "R9 unexpected memory request", mem_req_addr, '0);
        end else begin
          ev_t e;
          e = expq.pop_front();
          check(kind == e.kind && mem_req_addr == e.addr &&
                (kind == 0 || mem_req_wdata == e.data), e.req,
                {mem_req_addr[31:0], mem_req_wdata}, {e.addr[31:0], e.data});
        end
        rsp_pend  = 1'b1;
        rsp_is_wb = (kind == 2);
        wb_next   = (kind == 2);
        rsp_err_p = (mem_req_addr == err_addr);
        rsp_data_p = '0;
        if (!rsp_err_p) begin
          if (kind == 0)      rsp_data_p = rd_word(mem_req_addr);
          else if (kind == 1) mem_m[mem_req_addr] = mem_req_wdata[7:0];
          else                put_word(mem_req_addr, mem_req_wdata);
        end
      end
      // item side strobes
      if (item_sel_valid) begin
        if (expq.size() == 0 || expq[0].kind != 3) begin
          check(0, "R4 unexpected select", 64'(item_sel_key), '0);
        end else begin
          ev_t e;
          e = expq.pop_front();
          check(item_sel_key == e.data[15:0], e.req, 64'(item_sel_key), 64'(e.data));
        end
        src_key = item_sel_key;
        src_off = 0;
      end
      if (item_skip_valid) begin
        if (expq.size() == 0 || expq[0].kind != 4) begin
          check(0, "R6 unexpected skip", 64'(item_skip_len), '0);
        end else begin
          ev_t e;
          e = expq.pop_front();
          check(item_skip_len == e.data, e.req, 64'(item_skip_len), 64'(e.data));
        end
        src_off += item_skip_len;
      end
      // item byte stream
      item_data_valid = ($urandom_range(0, 2) != 0);
      item_data = item_byte(src_key, src_off);
      if (item_data_valid && item_data_ready) src_off++;
      // register start model
      if (reg_wr && reg_addr == 3'd4 && !exp_busy) nb = 1'b1;
      exp_busy = nb;
    end
  end

  initial begin
    logic [31:0] st;
    // reset state
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9 busy at reset", 64'(busy), 64'd0);
    check(mem_req_valid == 1'b0, "R10 no request at reset", 64'(mem_req_valid), 64'd0);
    #1 rst_n = 1'b1;
    // R1 identification reads
    reg_addr = 3'd0; #2;
    check(reg_rdata == 32'h5145_4D55, "R1 read offset 0", 64'(reg_rdata), 64'h5145_4D55);
    reg_addr = 3'd4; #2;
    check(reg_rdata == 32'h2043_4647, "R1 read offset 4", 64'(reg_rdata), 64'h2043_4647);

    // R2/R4/R5/R7: 64-bit descriptor address, select + read, input error bit set
    run_op(64'h0000_0001_0000_0100, 32'h1234_000B, 32'd5, 64'h0000_0000_0000_2000, "R5");
    // R2: upper half cleared, low-only address; read continues from current offset
    run_op(64'h0000_0000_0000_0200, 32'h0000_0002, 32'd3, 64'h0000_0000_0000_2010, "R2");
    // R6: select + skip, then read without select from the advanced position
    run_op(64'h0000_0000_0000_0300, 32'hBEEF_000C, 32'd10, 64'h0, "R6");
    run_op(64'h0000_0000_0000_0340, 32'h0000_0002, 32'd4, 64'h0000_0000_0000_2020, "R6");
    // R6: read and skip both set -> read only
    run_op(64'h0000_0000_0000_0380, 32'h0042_000E, 32'd6, 64'h0000_0000_0000_2030, "R6");
    // R5: zero-length read
    run_op(64'h0000_0000_0000_03C0, 32'h0007_000A, 32'd0, 64'h0000_0000_0000_2040, "R5");
    // R4: select only
    run_op(64'h0000_0000_0000_0400, 32'h00A5_0008, 32'd9, 64'h0, "R4");
    // R8: error on third descriptor word
    err_addr = 64'h0000_0000_0000_0448;
    run_op(64'h0000_0000_0000_0440, 32'h5555_000A, 32'd4, 64'h0000_0000_0000_2050, "R8");
    // R8: error on third byte write
    err_addr = 64'h0000_0000_0000_2062;
    run_op(64'h0000_0000_0000_0480, 32'h0101_000A, 32'd6, 64'h0000_0000_0000_2060, "R8");
    err_addr = '1;

    // R9: writes while busy are ignored
    put_desc(64'h0000_0000_0000_0500, 32'h0202_000A, 32'd12, 64'h0000_0000_0000_2100);
    put_desc(64'h0000_0000_0000_3000, 32'h0303_000A, 32'd2,  64'h0000_0000_0000_2200);
    plan_op(64'h0000_0000_0000_0500, 32'h0202_000A, 32'd12, 64'h0000_0000_0000_2100, st);
    launch(64'h0000_0000_0000_0500);
    repeat (3) @(negedge clk);
    reg_write(3'd0, 32'h0000_00AB);
    reg_write(3'd4, 32'h0000_3000);
    wait_idle("R9");
    // R9: upper half write while busy left no trace
    run_op(64'h0000_0000_0000_0540, 32'h0000_0002, 32'd2, 64'h0000_0000_0000_2110, "R9");

    // R9: start write in the cycle the status response completes
    put_desc(64'h0000_0000_0000_0580, 32'h0404_000A, 32'd3, 64'h0000_0000_0000_2120);
    plan_op(64'h0000_0000_0000_0580, 32'h0404_000A, 32'd3, 64'h0000_0000_0000_2120, st);
    launch(64'h0000_0000_0000_0580);
    collide(3'd4, 32'h0000_3000);
    wait_idle("R9");
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R9 colliding start ignored", 64'(busy), 64'd0);

    // R2: upper half write in the completion cycle is dropped
    put_desc(64'h0000_0000_0000_05C0, 32'h0505_000A, 32'd2, 64'h0000_0000_0000_2130);
    plan_op(64'h0000_0000_0000_05C0, 32'h0505_000A, 32'd2, 64'h0000_0000_0000_2130, st);
    launch(64'h0000_0000_0000_05C0);
    collide(3'd0, 32'hDEAD_BEEF);
    wait_idle("R2");
    run_op(64'h0000_0000_0000_0600, 32'h0000_0002, 32'd2, 64'h0000_0000_0000_2140, "R2");

    // R1 read again after activity
    @(negedge clk); #1 reg_addr = 3'd0; #2;
    check(reg_rdata == 32'h5145_4D55, "R1 read offset 0 later", 64'(reg_rdata), 64'h5145_4D55);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule